// File: doc/BRIEF.md
# Hidden Configuration Register Bank

This block holds a small byte-wide bank of timing and control registers. The bank shares its address window with a disk task-file port. After reset the bank is hidden: every access in the window goes to the task-file path, and reads return the task-file data. The host opens the bank with a short sequence of ordinary port accesses. Once the bank is open, a few offsets in the window reach configuration registers instead of the task file. A fixed byte write closes the bank again.

There are two sets of cycle timing, each with a read-timing byte and a write-timing byte. The lowest bit of the miscellaneous register selects which set offsets 0 and 1 reach. A mapping code in the control register decides which set each of the two drives uses. The selected timing bytes and the miscellaneous byte are driven out continuously to a cycle timing generator.

Top module: `hidden_cfg_port`

## Requirements
- R1: After reset the bank is closed. Both timing sets, the control register and the miscellaneous register hold 0x00, so every drive timing output and misc_o read 0x00.
- R2: The bank opens in the cycle after this exact sequence completes: a 16-bit read (acc_word_i=1) at offset 1, then another such read, then a byte write (acc_word_i=0) of 0x03 at offset 2. More than two key reads before the write still open the bank.
- R3: While the bank is closed, any other access breaks the sequence and returns the detector to its start. Examples are a byte read at offset 1, an access at another offset, a write placed between the two key reads, or a write at offset 2 of a value other than 0x03.
- R4: While the bank is open, a byte write of 0x83 at offset 2 closes it from the next cycle. A write of any other value at offset 2 leaves it open.
- R5: While the bank is closed, every read returns tf_rdata_i, and no write changes any configuration register.
- R6: While the bank is open, reads return register contents at these offsets: 0 (read timing), 1 (write timing), 3 (control), 5 (strap) and 6 (miscellaneous). Reads at offsets 2, 4 and 7 return tf_rdata_i. A write at offset 0, 1, 3 or 6 updates its register in the cycle after the write.
- R7: Bit 0 of the miscellaneous register selects the timing set that offsets 0 and 1 reach: 0 selects set A, 1 selects set B. The two sets keep separate values.
- R8: The strap register always reads the VERSION parameter (default 0x00), and writes to it are ignored.
- R9: Drive 0 always uses set A. Drive 1 uses set B only when the control register holds 0x85; otherwise drive 1 uses set A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | One port access in this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_word_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_off_i | input | 3 | Offset within the shared window |
| acc_wdata_i | input | 8 | Write data (byte lane) |
| tf_rdata_i | input | 8 | Read data from the task-file path |
| rdata_o | output | 8 | Read data returned to the host |
| cfg_mode_o | output | 1 | Bank is open |
| drv0_rd_tim_o | output | 8 | Read timing for drive 0 |
| drv0_wr_tim_o | output | 8 | Write timing for drive 0 |
| drv1_rd_tim_o | output | 8 | Read timing for drive 1 |
| drv1_wr_tim_o | output | 8 | Write timing for drive 1 |
| misc_o | output | 8 | Miscellaneous register |

## Verification
The opening sequence is tried in several forms. Each broken form tells a detector that checks width, offset and order apart from one that only counts accesses:
- a clean run;
- a write placed between the key reads;
- a byte-wide key read;
- a foreign-offset read placed before the key write;
- a wrong key value;
- three key reads followed by the key write.

Register access is tried with different values in set A and set B, so that a wrong bank index shows up both in the read-back and on the drive outputs. Locked writes followed by an unlock show whether any write leaked into the bank. Writes of a non-closing value and of the closing value at offset 2 separate the two close cases.

// File: rtl/hcfg_pkg.sv
package hcfg_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned OW = 3;

  localparam logic [OW-1:0] OFF_RD_TIM = 3'd0;
  localparam logic [OW-1:0] OFF_WR_TIM = 3'd1;
  localparam logic [OW-1:0] OFF_KEY_RD = 3'd1;
  localparam logic [OW-1:0] OFF_KEY_WR = 3'd2;
  localparam logic [OW-1:0] OFF_CTRL   = 3'd3;
  localparam logic [OW-1:0] OFF_STRAP  = 3'd5;
  localparam logic [OW-1:0] OFF_MISC   = 3'd6;

  localparam logic [DW-1:0] CODE_OPEN  = 8'h03;
  localparam logic [DW-1:0] CODE_CLOSE = 8'h83;
  localparam logic [DW-1:0] CODE_MAP   = 8'h85;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ONE  = 2'd1,
    SEQ_TWO  = 2'd2
  } seq_e;
endpackage

// File: rtl/hcfg_unlock.sv
module hcfg_unlock
  import hcfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_valid_i,
  input  logic          acc_write_i,
  input  logic          acc_word_i,
  input  logic [OW-1:0] acc_off_i,
  input  logic [DW-1:0] acc_wdata_i,
  output logic          cfg_mode_o
);
  seq_e seq_q, seq_d;
  logic mode_q, mode_d;
  logic key_rd, key_open, key_close;

  assign key_rd    = !acc_write_i && acc_word_i && (acc_off_i == OFF_KEY_RD);
  assign key_open  = acc_write_i && !acc_word_i && (acc_off_i == OFF_KEY_WR) &&
                     (acc_wdata_i == CODE_OPEN);
  assign key_close = acc_write_i && !acc_word_i && (acc_off_i == OFF_KEY_WR) &&
                     (acc_wdata_i == CODE_CLOSE);

  always_comb begin
    seq_d  = seq_q;
    mode_d = mode_q;
    if (acc_valid_i) begin
      if (mode_q) begin
        seq_d = SEQ_IDLE;
        if (key_close) mode_d = 1'b0;
      end else begin
        unique case (seq_q)
          SEQ_IDLE: seq_d = key_rd ? SEQ_ONE : SEQ_IDLE;
          SEQ_ONE:  seq_d = key_rd ? SEQ_TWO : SEQ_IDLE;
          SEQ_TWO: begin
            if (key_rd) begin
              seq_d = SEQ_TWO;
            end else begin
              seq_d = SEQ_IDLE;
              if (key_open) mode_d = 1'b1;
            end
          end
          default: seq_d = SEQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q  <= SEQ_IDLE;
      mode_q <= 1'b0;
    end else begin
      seq_q  <= seq_d;
      mode_q <= mode_d;
    end
  end

  assign cfg_mode_o = mode_q;

  // R2: opening only follows two key reads and the key write
  assert_open_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q) |-> $past(seq_q == SEQ_TWO) && $past(acc_valid_i) &&
      $past(acc_write_i) && !$past(acc_word_i) &&
      ($past(acc_off_i) == OFF_KEY_WR) && ($past(acc_wdata_i) == CODE_OPEN));

  // R3: a non-key access while locked drops the detector to idle
  assert_break_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !mode_q && !acc_write_i && !(acc_word_i && acc_off_i == OFF_KEY_RD))
      |=> seq_q == SEQ_IDLE);

  assert_seq_idle_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> seq_q == SEQ_IDLE);

  // R4: closing only on the close code
  assert_close_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mode_q) |-> $past(acc_valid_i) && $past(acc_write_i) && !$past(acc_word_i) &&
      ($past(acc_off_i) == OFF_KEY_WR) && ($past(acc_wdata_i) == CODE_CLOSE));
endmodule

// File: rtl/hcfg_regs.sv
module hcfg_regs
  import hcfg_pkg::*;
#(
  parameter int unsigned NUM_SETS = 2,
  parameter logic [7:0]  VERSION  = 8'h00
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_en_i,
  input  logic                         acc_valid_i,
  input  logic                         acc_write_i,
  input  logic [OW-1:0]                acc_off_i,
  input  logic [DW-1:0]                acc_wdata_i,
  output logic                         hit_o,
  output logic [DW-1:0]                rdata_o,
  output logic [NUM_SETS-1:0][DW-1:0]  set_rd_o,
  output logic [NUM_SETS-1:0][DW-1:0]  set_wr_o,
  output logic [DW-1:0]                ctrl_o,
  output logic [DW-1:0]                misc_o
);
  localparam int unsigned IDX_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;

  logic [NUM_SETS-1:0][DW-1:0] rd_q, wr_q;
  logic [DW-1:0] ctrl_q, misc_q;
  logic [IDX_W-1:0] sel;
  logic wr_en;

  assign sel   = misc_q[IDX_W-1:0];
  assign wr_en = cfg_en_i && acc_valid_i && acc_write_i;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_q[s] <= '0;
        wr_q[s] <= '0;
      end else if (wr_en && (sel == IDX_W'(s))) begin
        if (acc_off_i == OFF_RD_TIM) rd_q[s] <= acc_wdata_i;
        if (acc_off_i == OFF_WR_TIM) wr_q[s] <= acc_wdata_i;
      end
    end

    // R5: a locked port never touches a timing set
    assert_locked_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_en_i |=> $stable(rd_q[s]) && $stable(wr_q[s]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      misc_q <= '0;
    end else if (wr_en) begin
      if (acc_off_i == OFF_CTRL) ctrl_q <= acc_wdata_i;
      if (acc_off_i == OFF_MISC) misc_q <= acc_wdata_i;
    end
  end

  always_comb begin
    hit_o   = cfg_en_i;
    rdata_o = '0;
    unique case (acc_off_i)
      OFF_RD_TIM: rdata_o = rd_q[sel];
      OFF_WR_TIM: rdata_o = wr_q[sel];
      OFF_CTRL:   rdata_o = ctrl_q;
      OFF_STRAP:  rdata_o = VERSION;
      OFF_MISC:   rdata_o = misc_q;
      default:    hit_o   = 1'b0;
    endcase
  end

  assign set_rd_o = rd_q;
  assign set_wr_o = wr_q;
  assign ctrl_o   = ctrl_q;
  assign misc_o   = misc_q;

  assert_locked_ctl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(ctrl_q) && $stable(misc_q));

  // R6: a write at the control offset lands in the control register
  assert_ctrl_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && acc_off_i == OFF_CTRL) |=> ctrl_q == $past(acc_wdata_i));
endmodule

// File: rtl/hcfg_drive_map.sv
module hcfg_drive_map
  import hcfg_pkg::*;
#(
  parameter int unsigned NUM_SETS = 2
) (
  input  logic [NUM_SETS-1:0][DW-1:0] set_rd_i,
  input  logic [NUM_SETS-1:0][DW-1:0] set_wr_i,
  input  logic [DW-1:0]               ctrl_i,
  output logic [DW-1:0]               drv0_rd_o,
  output logic [DW-1:0]               drv0_wr_o,
  output logic [DW-1:0]               drv1_rd_o,
  output logic [DW-1:0]               drv1_wr_o
);
  logic split;
  assign split     = (ctrl_i == CODE_MAP);
  assign drv0_rd_o = set_rd_i[0];
  assign drv0_wr_o = set_wr_i[0];
  assign drv1_rd_o = split ? set_rd_i[1] : set_rd_i[0];
  assign drv1_wr_o = split ? set_wr_i[1] : set_wr_i[0];
endmodule

// File: rtl/hidden_cfg_port.sv
module hidden_cfg_port
  import hcfg_pkg::*;
#(
  parameter int unsigned NUM_SETS = 2,
  parameter logic [7:0]  VERSION  = 8'h00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_valid_i,
  input  logic          acc_write_i,
  input  logic          acc_word_i,
  input  logic [2:0]    acc_off_i,
  input  logic [7:0]    acc_wdata_i,
  input  logic [7:0]    tf_rdata_i,
  output logic [7:0]    rdata_o,
  output logic          cfg_mode_o,
  output logic [7:0]    drv0_rd_tim_o,
  output logic [7:0]    drv0_wr_tim_o,
  output logic [7:0]    drv1_rd_tim_o,
  output logic [7:0]    drv1_wr_tim_o,
  output logic [7:0]    misc_o
);
  logic cfg_mode, hit;
  logic [DW-1:0] cfg_rdata, ctrl;
  logic [NUM_SETS-1:0][DW-1:0] set_rd, set_wr;

  hcfg_unlock u_unlock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid_i),
    .acc_write_i (acc_write_i),
    .acc_word_i  (acc_word_i),
    .acc_off_i   (acc_off_i),
    .acc_wdata_i (acc_wdata_i),
    .cfg_mode_o  (cfg_mode)
  );

  hcfg_regs #(.NUM_SETS(NUM_SETS), .VERSION(VERSION)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_en_i    (cfg_mode),
    .acc_valid_i (acc_valid_i),
    .acc_write_i (acc_write_i),
    .acc_off_i   (acc_off_i),
    .acc_wdata_i (acc_wdata_i),
    .hit_o       (hit),
    .rdata_o     (cfg_rdata),
    .set_rd_o    (set_rd),
    .set_wr_o    (set_wr),
    .ctrl_o      (ctrl),
    .misc_o      (misc_o)
  );

  hcfg_drive_map #(.NUM_SETS(NUM_SETS)) u_map (
    .set_rd_i  (set_rd),
    .set_wr_i  (set_wr),
    .ctrl_i    (ctrl),
    .drv0_rd_o (drv0_rd_tim_o),
    .drv0_wr_o (drv0_wr_tim_o),
    .drv1_rd_o (drv1_rd_tim_o),
    .drv1_wr_o (drv1_wr_tim_o)
  );

  assign rdata_o    = hit ? cfg_rdata : tf_rdata_i;
  assign cfg_mode_o = cfg_mode;

  // R5: locked reads follow the task-file path
  assert_locked_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_write_i && !cfg_mode_o) |-> rdata_o == tf_rdata_i);

  // R8: strap reads the version constant
  assert_strap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_write_i && cfg_mode_o && acc_off_i == OFF_STRAP)
      |-> rdata_o == VERSION);

  // R9: drive 0 never depends on the control code
  assert_drv0_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_mode_o) |=> $stable(drv0_rd_tim_o) && $stable(drv0_wr_tim_o));
endmodule

// File: tb/tb_hidden_cfg_port.sv
`timescale 1ns/1ps
module tb_hidden_cfg_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_word = 1'b0;
  logic [2:0] acc_off = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] tf_rdata = 8'hEE;
  logic [7:0] rdata, d0r, d0w, d1r, d1w, misc;
  logic cfg_mode;
  int checks = 0, errors = 0;
  logic [7:0] rd;

  always #2.5 clk = ~clk;

  hidden_cfg_port dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .acc_word_i(acc_word), .acc_off_i(acc_off), .acc_wdata_i(acc_wdata),
    .tf_rdata_i(tf_rdata), .rdata_o(rdata), .cfg_mode_o(cfg_mode),
    .drv0_rd_tim_o(d0r), .drv0_wr_tim_o(d0w), .drv1_rd_tim_o(d1r),
    .drv1_wr_tim_o(d1w), .misc_o(misc)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic wd, input logic [2:0] off,
                     input logic [7:0] wdat, output logic [7:0] r);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_word = wd; acc_off = off; acc_wdata = wdat;
    #1 r = rdata;
    @(posedge clk);
    #1 acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic wr8(input logic [2:0] off, input logic [7:0] d);
    logic [7:0] x;
    acc(1'b1, 1'b0, off, d, x);
  endtask

  task automatic rd8(input logic [2:0] off, output logic [7:0] r);
    acc(1'b0, 1'b0, off, 8'h00, r);
  endtask

  task automatic key_rd();
    logic [7:0] x;
    acc(1'b0, 1'b1, 3'd1, 8'h00, x);
  endtask

  task automatic unlock();
    key_rd(); key_rd(); wr8(3'd2, 8'h03);
  endtask

  task automatic t_reset();
    chk("R1 cfg_mode", {7'd0, cfg_mode}, 8'h00);
    chk("R1 drv0_rd", d0r, 8'h00);
    chk("R1 drv1_wr", d1w, 8'h00);
    chk("R1 misc", misc, 8'h00);
  endtask

  task automatic t_locked();
    tf_rdata = 8'h5A;
    rd8(3'd0, rd); chk("R5 locked read off0", rd, 8'h5A);
    rd8(3'd6, rd); chk("R5 locked read off6", rd, 8'h5A);
    wr8(3'd0, 8'h55); wr8(3'd3, 8'h85); wr8(3'd6, 8'h01);
    chk("R5 locked write drv0", d0r, 8'h00);
    chk("R5 locked write misc", misc, 8'h00);
    tf_rdata = 8'hEE;
  endtask

  task automatic t_break();
    key_rd(); wr8(3'd4, 8'h00); key_rd(); wr8(3'd2, 8'h03);
    chk("R3 write between reads", {7'd0, cfg_mode}, 8'h00);
    key_rd(); acc(1'b0, 1'b0, 3'd1, 8'h00, rd); key_rd(); wr8(3'd2, 8'h03);
    chk("R3 byte key read", {7'd0, cfg_mode}, 8'h00);
    key_rd(); key_rd(); rd8(3'd7, rd); wr8(3'd2, 8'h03);
    chk("R3 foreign offset", {7'd0, cfg_mode}, 8'h00);
    key_rd(); key_rd(); wr8(3'd2, 8'h04); wr8(3'd2, 8'h03);
    chk("R3 wrong key value", {7'd0, cfg_mode}, 8'h00);
    rd8(3'd0, rd); chk("R3 still hidden", rd, 8'hEE);
  endtask

  task automatic t_unlock();
    key_rd(); key_rd(); key_rd(); wr8(3'd2, 8'h03);
    chk("R2 open after three reads", {7'd0, cfg_mode}, 8'h01);
    rd8(3'd0, rd); chk("R2/R5 timing untouched by locked writes", rd, 8'h00);
  endtask

  task automatic t_regmap();
    wr8(3'd0, 8'h11); wr8(3'd1, 8'h22); wr8(3'd3, 8'h33); wr8(3'd6, 8'h40);
    rd8(3'd0, rd); chk("R6 read timing", rd, 8'h11);
    rd8(3'd1, rd); chk("R6 write timing", rd, 8'h22);
    rd8(3'd3, rd); chk("R6 control", rd, 8'h33);
    rd8(3'd6, rd); chk("R6 misc", rd, 8'h40);
    chk("R6 misc_o", misc, 8'h40);
    rd8(3'd4, rd); chk("R6 off4 passthrough", rd, 8'hEE);
    rd8(3'd2, rd); chk("R6 off2 passthrough", rd, 8'hEE);
    rd8(3'd7, rd); chk("R6 off7 passthrough", rd, 8'hEE);
  endtask

  task automatic t_banks();
    wr8(3'd6, 8'h01); wr8(3'd0, 8'hA1); wr8(3'd1, 8'hA2);
    rd8(3'd0, rd); chk("R7 set B read timing", rd, 8'hA1);
    wr8(3'd6, 8'h00);
    rd8(3'd0, rd); chk("R7 set A kept", rd, 8'h11);
    rd8(3'd1, rd); chk("R7 set A write kept", rd, 8'h22);
    wr8(3'd6, 8'h41);
    rd8(3'd1, rd); chk("R7 set B write timing", rd, 8'hA2);
  endtask

  task automatic t_strap();
    rd8(3'd5, rd); chk("R8 strap version", rd, 8'h00);
    wr8(3'd5, 8'h7F);
    rd8(3'd5, rd); chk("R8 strap write ignored", rd, 8'h00);
  endtask

  task automatic t_map();
    chk("R9 drv1 on A without code", d1r, 8'h11);
    wr8(3'd3, 8'h85);
    chk("R9 drv0 rd on A", d0r, 8'h11);
    chk("R9 drv0 wr on A", d0w, 8'h22);
    chk("R9 drv1 rd on B", d1r, 8'hA1);
    chk("R9 drv1 wr on B", d1w, 8'hA2);
    wr8(3'd3, 8'h84);
    chk("R9 drv1 back to A", d1w, 8'h22);
  endtask

  task automatic t_lock();
    wr8(3'd2, 8'h12);
    chk("R4 other value keeps open", {7'd0, cfg_mode}, 8'h01);
    rd8(3'd3, rd); chk("R4 still open read", rd, 8'h84);
    wr8(3'd2, 8'h83);
    chk("R4 close code", {7'd0, cfg_mode}, 8'h00);
    rd8(3'd3, rd); chk("R4 hidden after close", rd, 8'hEE);
    wr8(3'd0, 8'h99);
    chk("R5 locked write after close", d0r, 8'h11);
  endtask

  initial begin
    fork
      begin
        #20 rst_n = 1'b1;
        #1 t_reset();
        t_locked();
        t_break();
        t_unlock();
        t_regmap();
        t_banks();
        t_strap();
        t_map();
        t_lock();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule